// File: doc/BRIEF.md
# Shared Receive Character Silo for a Sixteen-Line Serial Multiplexer

This block collects characters from sixteen independent asynchronous receivers into a single first-in first-out store (the silo). Each stored entry records the character, the line it came from, and its error flags. A host drains the silo through a small register port. Each read of the receive register removes one entry. The top bit of the returned word tells the host whether the word holds a character, so a driver can keep reading while the value is negative.

Every receiver owns one holding register. When several lines deliver in the same cycle, the lowest-numbered waiting line is moved into the silo first, and one line is moved per cycle. Characters can be lost in two ways: the silo is full, or a line delivers again before its previous character has left the holding register. In both cases the next character written into the silo carries an overrun mark.

The control register has two flags, each with its own enable. The receiver flag is set whenever the silo holds anything. The storage flag is set once the silo fill reaches a programmable alarm level. The control register also has a maintenance-mode bit, which is brought out on a pin, and a master-clear command.

Top module: `silo_rx`

## Requirements
- R1: A receive word holds the following fields. Bit 15 is 1 for a valid character. Bit 14 is overrun, bit 13 is framing error, bit 12 is parity error, bits 11..8 are the line number and bits 7..0 are the character. Reading the receive register while the silo is empty returns 16'h0000.
- R2: The register port has three addresses. Address 0 is the control register, address 1 is the receive register and address 2 is the alarm level (7 bits). The read data appears on `reg_rdata` one clock after the cycle in which `reg_rd` is high, and it holds until the next read.
- R3: Entries leave the silo in the order they entered. Characters that arrive on several lines in the same cycle are stored in ascending line order, one per cycle.
- R4: Each read of address 1 removes exactly one entry. A read while the silo is empty removes nothing.
- R5: The silo holds 64 entries. A character offered while 64 entries are stored is discarded. Bit 14 is set in the next entry that is written and cleared in the one after it.
- R6: A character that arrives on a line whose previous character is still in the holding register replaces it. The loss sets bit 14 in the next entry written into the silo.
- R7: Control bit 7 reads 1 exactly when the silo is not empty. `irq_rx` equals that flag ANDed with control bit 6.
- R8: Control bit 14 (storage flag) sets once the fill is greater than or equal to the alarm level. A control write with bit 14 = 0 clears it, provided the fill is then below the level. `irq_store` equals the flag ANDed with control bit 12.
- R9: Writing control bit 11 = 1 does all of the following: empties the silo, drops waiting characters including any that arrive in that cycle, clears all flags, enables and maintenance mode, and returns the alarm level to 16. Bit 11 reads back as 0.
- R10: Control bit 9 is readable and writable and drives `loop_en`.
- R11: After reset the control register reads 16'h0000, the alarm level reads 16, and both interrupt outputs and `loop_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 16 | One-cycle strobe per line: a character is delivered |
| rx_data | input | 128 | Characters, line i in bits 8i+7..8i |
| rx_perr | input | 16 | Parity error with the character, per line |
| rx_ferr | input | 16 | Framing error (break) with the character, per line |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq_rx | output | 1 | Receiver interrupt request |
| irq_store | output | 1 | Storage (alarm) interrupt request |
| loop_en | output | 1 | Maintenance (loopback) mode select |

## Verification
Line overrun is the hardest case to reach from the ports. A line must deliver a second character while its first is still waiting in the holding register. That happens only while the arbiter is busy with lower-numbered lines. The bench therefore strobes lines 0 to 3 together and strobes line 3 again on the very next cycle. It then expects the overrun mark on the entry written one cycle after the loss, which is line 1's entry.

The full-silo drop is reached by feeding 64 characters on rotating lines, one per cycle, then offering one more. The bench checks that the overrun mark appears on the first character written after the silo is drained, and is gone from the next one.

// File: rtl/silo_pkg.sv
`timescale 1ns/1ps
package silo_pkg;
    localparam int CHAR_W = 8;
    localparam int TAG_W  = 4;
    localparam int WORD_W = 16;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [TAG_W-1:0]  line;
        logic [CHAR_W-1:0] chr;
    } silo_entry_t;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_RXD   = 2'd1,
        ADDR_ALARM = 2'd2
    } silo_addr_e;

    localparam int CTL_STORE_FLAG = 14;
    localparam int CTL_STORE_EN   = 12;
    localparam int CTL_MCLR       = 11;
    localparam int CTL_MAINT      = 9;
    localparam int CTL_RX_FLAG    = 7;
    localparam int CTL_RX_EN      = 6;
endpackage

// File: rtl/silo_arbiter.sv
`timescale 1ns/1ps
module silo_arbiter #(
    parameter int NUM_LINES = 16,
    parameter int CHAR_W    = 8,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic [NUM_LINES-1:0]          rx_valid,
    input  logic [NUM_LINES*CHAR_W-1:0]   rx_data,
    input  logic [NUM_LINES-1:0]          rx_perr,
    input  logic [NUM_LINES-1:0]          rx_ferr,
    output logic                          push,
    output logic [LINE_W-1:0]             push_line,
    output logic [CHAR_W-1:0]             push_chr,
    output logic                          push_perr,
    output logic                          push_ferr,
    output logic                          lost
);
    typedef struct packed {
        logic [NUM_LINES-1:0]             v;
        logic [NUM_LINES-1:0]             pe;
        logic [NUM_LINES-1:0]             fe;
        logic [NUM_LINES-1:0][CHAR_W-1:0] chr;
    } hold_t;

    hold_t             s_d, s_q;
    logic              found;
    logic [LINE_W-1:0] gsel;
    logic              lost_c;

    always_comb begin
        s_d    = s_q;
        found  = 1'b0;
        gsel   = '0;
        lost_c = 1'b0;
        // lowest-numbered waiting line wins
        for (int i = 0; i < NUM_LINES; i++) begin
            if (s_q.v[i] && !found) begin
                found = 1'b1;
                gsel  = LINE_W'(i);
            end
        end
        if (found) s_d.v[gsel] = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (rx_valid[i]) begin
                if (s_q.v[i] && !(found && gsel == LINE_W'(i))) lost_c = 1'b1;
                s_d.v[i]   = 1'b1;
                s_d.pe[i]  = rx_perr[i];
                s_d.fe[i]  = rx_ferr[i];
                s_d.chr[i] = rx_data[i*CHAR_W +: CHAR_W];
            end
        end
        if (clr) begin
            s_d    = '0;
            lost_c = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign push      = found;
    assign push_line = gsel;
    assign push_chr  = s_q.chr[gsel];
    assign push_perr = s_q.pe[gsel];
    assign push_ferr = s_q.fe[gsel];
    assign lost      = lost_c;

    // a granted line is released unless it is refilled in the same cycle
    p_grant_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && !rx_valid[push_line]) |=> !s_q.v[$past(push_line)]);

    // a loss needs an occupied holding register
    p_lost_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> (|s_q.v));
endmodule

// File: rtl/silo_fifo.sv
`timescale 1ns/1ps
module silo_fifo
    import silo_pkg::*;
#(
    parameter int DEPTH   = 64,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  silo_entry_t       push_entry,
    input  logic              lost,
    input  logic              pop_req,
    output silo_entry_t       head,
    output logic [CNT_W-1:0]  count
);
    typedef struct packed {
        silo_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
        logic                    ovf;
    } fifo_t;

    fifo_t       s_d, s_q;
    logic        do_push, do_pop;
    silo_entry_t wentry;

    always_comb begin
        s_d     = s_q;
        do_pop  = pop_req && (s_q.cnt != '0);
        do_push = push && (s_q.cnt != CNT_W'(DEPTH));
        wentry  = push_entry;
        wentry.ovr = s_q.ovf;
        if (do_push) begin
            s_d.mem[s_q.wr] = wentry;
            s_d.wr  = (s_q.wr == PTR_W'(DEPTH - 1)) ? '0 : s_q.wr + 1'b1;
            s_d.ovf = lost;
        end else begin
            s_d.ovf = s_q.ovf | lost | push;
        end
        if (do_pop)
            s_d.rd = (s_q.rd == PTR_W'(DEPTH - 1)) ? '0 : s_q.rd + 1'b1;
        s_d.cnt = s_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        if (clr) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rd];
    assign count = s_q.cnt;

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));
    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && s_q.cnt == CNT_W'(DEPTH) && !pop_req && !clr) |=> s_q.cnt == CNT_W'(DEPTH));
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && s_q.cnt == '0 && !push && !clr) |=> s_q.cnt == '0);
    p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> s_q.cnt == '0);
endmodule

// File: rtl/silo_rx.sv
`timescale 1ns/1ps
module silo_rx
    import silo_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int DEPTH     = 64,
    parameter int ALARM_RST = 16,
    localparam int LINE_W   = $clog2(NUM_LINES),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LINES-1:0]          rx_valid,
    input  logic [NUM_LINES*CHAR_W-1:0]   rx_data,
    input  logic [NUM_LINES-1:0]          rx_perr,
    input  logic [NUM_LINES-1:0]          rx_ferr,
    input  logic [1:0]                    reg_addr,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [WORD_W-1:0]             reg_wdata,
    output logic [WORD_W-1:0]             reg_rdata,
    output logic                          irq_rx,
    output logic                          irq_store,
    output logic                          loop_en
);
    typedef struct packed {
        logic              store_en;
        logic              rx_en;
        logic              maint;
        logic              store_flag;
        logic [CNT_W-1:0]  alarm;
        logic [WORD_W-1:0] rdata;
    } regs_t;

    localparam regs_t REGS_RST = '{store_en: 1'b0, rx_en: 1'b0, maint: 1'b0,
                                   store_flag: 1'b0, alarm: CNT_W'(ALARM_RST),
                                   rdata: '0};

    regs_t             r_d, r_q;
    logic              mclr, pop_req;
    logic              a_push, a_perr, a_ferr, a_lost;
    logic [LINE_W-1:0] a_line;
    logic [CHAR_W-1:0] a_chr;
    silo_entry_t       a_entry, head;
    logic [CNT_W-1:0]  count;
    logic [WORD_W-1:0] ctrl_word;
    logic              unused_wdata;

    assign mclr    = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[CTL_MCLR];
    assign pop_req = reg_rd && (reg_addr == ADDR_RXD) && !mclr;

    silo_arbiter #(.NUM_LINES(NUM_LINES), .CHAR_W(CHAR_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .clr(mclr),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .push(a_push), .push_line(a_line), .push_chr(a_chr),
        .push_perr(a_perr), .push_ferr(a_ferr), .lost(a_lost)
    );

    always_comb begin
        a_entry      = '0;
        a_entry.line = TAG_W'(a_line);
        a_entry.chr  = a_chr;
        a_entry.perr = a_perr;
        a_entry.ferr = a_ferr;
    end

    silo_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(mclr),
        .push(a_push), .push_entry(a_entry), .lost(a_lost),
        .pop_req(pop_req), .head(head), .count(count)
    );

    always_comb begin
        ctrl_word                 = '0;
        ctrl_word[CTL_STORE_FLAG] = r_q.store_flag;
        ctrl_word[CTL_STORE_EN]   = r_q.store_en;
        ctrl_word[CTL_MAINT]      = r_q.maint;
        ctrl_word[CTL_RX_FLAG]    = (count != '0);
        ctrl_word[CTL_RX_EN]      = r_q.rx_en;
    end

    always_comb begin
        r_d = r_q;
        if (reg_wr && reg_addr == ADDR_CTRL) begin
            r_d.store_en = reg_wdata[CTL_STORE_EN];
            r_d.rx_en    = reg_wdata[CTL_RX_EN];
            r_d.maint    = reg_wdata[CTL_MAINT];
            if (!reg_wdata[CTL_STORE_FLAG]) r_d.store_flag = 1'b0;
        end
        if (reg_wr && reg_addr == ADDR_ALARM)
            r_d.alarm = reg_wdata[CNT_W-1:0];
        if (count >= r_q.alarm)
            r_d.store_flag = 1'b1;
        if (reg_rd) begin
            if (reg_addr == ADDR_CTRL)
                r_d.rdata = ctrl_word;
            else if (reg_addr == ADDR_RXD)
                r_d.rdata = (count != '0) ? {1'b1, head} : '0;
            else if (reg_addr == ADDR_ALARM)
                r_d.rdata = WORD_W'(r_q.alarm);
            else
                r_d.rdata = '0;
        end
        if (mclr) r_d = REGS_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign reg_rdata    = r_q.rdata;
    assign irq_rx       = r_q.rx_en & (count != '0);
    assign irq_store    = r_q.store_en & r_q.store_flag;
    assign loop_en      = r_q.maint;
    assign unused_wdata = ^{reg_wdata[15], reg_wdata[13], reg_wdata[10], reg_wdata[8:7]};

    p_mclear_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (count == '0) && !irq_rx && !irq_store && !loop_en);
    p_store_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= r_q.alarm && !mclr) |=> r_q.store_flag);
    p_empty_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_RXD && count == '0 && !mclr) |=> reg_rdata == '0);
endmodule

// File: tb/silo_rx_test.sv
`timescale 1ns/1ps
module silo_rx_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  rx_valid = '0;
    logic [127:0] rx_data = '0;
    logic [15:0]  rx_perr = '0;
    logic [15:0]  rx_ferr = '0;
    logic [1:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic         reg_rd = 1'b0;
    logic [15:0]  reg_wdata = '0;
    logic [15:0]  reg_rdata;
    logic         irq_rx, irq_store, loop_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    silo_rx uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_rx(irq_rx), .irq_store(irq_store),
        .loop_en(loop_en)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic put(input int line, input logic [7:0] c, input bit pe, input bit fe);
        rx_valid[line] = 1'b1;
        rx_data[line*8 +: 8] = c;
        rx_perr[line] = pe;
        rx_ferr[line] = fe;
    endtask

    task automatic release_rx();
        rx_valid = '0; rx_perr = '0; rx_ferr = '0;
    endtask

    task automatic expect_rx(input string req, input logic [15:0] exp);
        logic [15:0] v;
        rd(2'd1, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R11 irq_rx", {15'd0, irq_rx}, 16'd0);
        chk("R11 irq_store", {15'd0, irq_store}, 16'd0);
        chk("R11 loop_en", {15'd0, loop_en}, 16'd0);
        rd(2'd0, v); chk("R11 ctrl", v, 16'h0000);
        rd(2'd2, v); chk("R11 alarm", v, 16'd16);
        rd(2'd1, v); chk("R1 empty read", v, 16'h0000);
    endtask

    task automatic t_single();
        logic [15:0] v;
        wr(2'd0, 16'h0040);
        @(negedge clk); put(5, 8'h41, 1'b1, 1'b0);
        @(negedge clk); release_rx();
        idle(2);
        chk("R7 irq_rx", {15'd0, irq_rx}, 16'd1);
        rd(2'd0, v); chk("R7 ctrl flags", v, 16'h00C0);
        expect_rx("R1 parity word", 16'h9541);
        // R2: read data holds after the strobe
        idle(2); chk("R2 rdata held", reg_rdata, 16'h9541);
        expect_rx("R4 empty after one pop", 16'h0000);
        chk("R7 irq_rx low", {15'd0, irq_rx}, 16'd0);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_simultaneous();
        @(negedge clk);
        put(9, 8'h99, 1'b0, 1'b0);
        put(2, 8'h22, 1'b0, 1'b0);
        put(14, 8'hEE, 1'b0, 1'b1);
        @(negedge clk); release_rx();
        idle(4);
        expect_rx("R3 first line 2", 16'h8222);
        expect_rx("R3 second line 9", 16'h8999);
        expect_rx("R3 third line 14 framing", 16'hAEEE);
        expect_rx("R4 drained", 16'h0000);
    endtask

    task automatic t_line_overrun();
        @(negedge clk);
        for (int i = 0; i < 4; i++) put(i, 8'(8'h10 + i), 1'b0, 1'b0);
        @(negedge clk);
        release_rx();
        put(3, 8'h33, 1'b0, 1'b0);
        @(negedge clk); release_rx();
        idle(5);
        expect_rx("R6 line 0 clean", 16'h8010);
        expect_rx("R6 line 1 marked", 16'hC111);
        expect_rx("R6 line 2 clean", 16'h8212);
        expect_rx("R6 line 3 replaced", 16'h8333);
        expect_rx("R6 drained", 16'h0000);
    endtask

    task automatic t_alarm();
        logic [15:0] v;
        wr(2'd2, 16'd3);
        wr(2'd0, 16'h1000);
        @(negedge clk); put(0, 8'h01, 1'b0, 1'b0); put(1, 8'h02, 1'b0, 1'b0);
        @(negedge clk); release_rx();
        idle(4);
        chk("R8 below level", {15'd0, irq_store}, 16'd0);
        @(negedge clk); put(4, 8'h03, 1'b0, 1'b0);
        @(negedge clk); release_rx();
        idle(4);
        chk("R8 level reached", {15'd0, irq_store}, 16'd1);
        rd(2'd0, v); chk("R8 ctrl flags", v, 16'h5080);
        for (int i = 0; i < 3; i++) rd(2'd1, v);
        idle(2);
        chk("R8 flag sticky", {15'd0, irq_store}, 16'd1);
        wr(2'd0, 16'h1000);
        idle(2);
        chk("R8 flag cleared", {15'd0, irq_store}, 16'd0);
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'd16);
    endtask

    task automatic t_full();
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            release_rx();
            put(i % 16, 8'(i), 1'b0, 1'b0);
        end
        @(negedge clk); release_rx();
        idle(3);
        @(negedge clk); put(0, 8'hAA, 1'b0, 1'b0);
        @(negedge clk); release_rx();
        idle(3);
        for (int i = 0; i < 64; i++)
            expect_rx("R5 stored entry", 16'h8000 | 16'((i % 16) << 8) | 16'(i));
        expect_rx("R5 extra dropped", 16'h0000);
        @(negedge clk); put(7, 8'h55, 1'b0, 1'b0);
        @(negedge clk); release_rx();
        idle(3);
        @(negedge clk); put(7, 8'h56, 1'b0, 1'b0);
        @(negedge clk); release_rx();
        idle(3);
        expect_rx("R5 overrun marked", 16'hC755);
        expect_rx("R5 overrun cleared", 16'h8756);
    endtask

    task automatic t_maint_clear();
        logic [15:0] v;
        wr(2'd0, 16'h1240);
        chk("R10 loop_en", {15'd0, loop_en}, 16'd1);
        rd(2'd0, v); chk("R10 ctrl readback", v, 16'h1240);
        wr(2'd2, 16'd5);
        @(negedge clk); put(1, 8'h11, 1'b0, 1'b0); put(2, 8'h22, 1'b0, 1'b0);
        @(negedge clk); release_rx();
        idle(3);
        @(negedge clk);
        put(6, 8'h66, 1'b0, 1'b0);
        reg_addr = 2'd0; reg_wdata = 16'h0800; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; release_rx();
        idle(3);
        chk("R9 irq_rx", {15'd0, irq_rx}, 16'd0);
        chk("R9 loop_en", {15'd0, loop_en}, 16'd0);
        rd(2'd0, v); chk("R9 ctrl", v, 16'h0000);
        rd(2'd2, v); chk("R9 alarm", v, 16'd16);
        expect_rx("R9 silo empty", 16'h0000);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_single();
        t_simultaneous();
        t_line_overrun();
        t_alarm();
        t_full();
        t_maint_clear();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule